// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs one bit-level operation per cycle on an 8-bit operand. A caller presents the byte, a bit index, an operation code and the current carry (C) and zero (Z) flags. One clock later the unit returns a result byte, a write-back enable and updated C and Z flags. The caller uses the write-back enable to decide whether the byte must be stored again.

The operations fall into four groups. The first group sets, clears or flips the selected bit. The second group tests the selected bit into Z. The third group moves a bit between the byte and C, in either direction, with an optional inversion. The fourth group combines the selected bit, or its complement, with C using AND, OR or XOR. Any flag that an operation does not name is passed through unchanged. Address generation and memory access belong to the surrounding datapath.

Top module: `bitop_unit`

## Requirements
- R1: Only the low 3 bits of `idx_in` select the bit position (index 13 acts as index 5), and the mask has a single 1 at that position.
- R2: Op codes 0 (set), 1 (clear) and 2 (flip) force the selected bit to 1, force it to 0, or invert it. All other bits are kept, and `wb_en` is 1.
- R3: Op code 3 (test) returns the byte unchanged with `wb_en` 0. It sets `z_out` to 1 exactly when the selected bit is 0, and it leaves C as it was.
- R4: Op code 4 copies the selected bit into `c_out`, and op code 5 copies its complement. The byte is returned unchanged and `wb_en` is 0.
- R5: Op code 6 writes C into the selected bit, and op code 7 writes the complement of C. `wb_en` is 1 and C is kept.
- R6: Op codes 8/10/12 set `c_out` to C AND, OR or XOR the selected bit. Op codes 9/11/13 do the same with the complement of the bit. The byte is returned unchanged and `wb_en` is 0.
- R7: `z_out` equals `z_in` for every op code except 3. `c_out` equals `c_in` for op codes 0 to 3, 6 and 7.
- R8: Op codes 14 and 15 are no-operations: the byte and both flags pass through, and `wb_en` is 0.
- R9: Results appear one clock after the operation is accepted, with `out_valid` high. When `in_valid` is low, the next cycle has `out_valid` and `wb_en` both 0.
- R10: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_in | input | 4 | Operation code |
| data_in | input | 8 | Operand byte |
| idx_in | input | 4 | Bit index; the low 3 bits are used |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Result valid |
| wb_en | output | 1 | Result byte must be written back |
| data_out | output | 8 | Result byte |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |

## Verification
The output register is the only state, so any internal fault shows up on the ports in the cycle right after the operation. A decode fault that sends an op to the wrong group shows up as a wrong `wb_en`, or as a flag that moves when it should hold. A mask fault shows up as a changed bit other than the one selected, or as a fault only at high or aliased indices. For this reason the vectors cover every op code and spread the indices across the byte, including one above 7.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_SET  = 4'd0,
        OP_CLR  = 4'd1,
        OP_FLIP = 4'd2,
        OP_TST  = 4'd3,
        OP_LD   = 4'd4,
        OP_ILD  = 4'd5,
        OP_ST   = 4'd6,
        OP_IST  = 4'd7,
        OP_AND  = 4'd8,
        OP_IAND = 4'd9,
        OP_OR   = 4'd10,
        OP_IOR  = 4'd11,
        OP_XOR  = 4'd12,
        OP_IXOR = 4'd13,
        OP_NOP0 = 4'd14,
        OP_NOP1 = 4'd15
    } bit_op_e;

    typedef enum logic [2:0] {
        BY_KEEP, BY_SET, BY_CLR, BY_FLIP, BY_STORE
    } byte_act_e;

    typedef enum logic [2:0] {
        CF_KEEP, CF_LOAD, CF_AND, CF_OR, CF_XOR
    } carry_act_e;

    typedef struct packed {
        byte_act_e  by;
        carry_act_e cf;
        logic       ztest;
        logic       inv;
    } bit_ctrl_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [3:0] op,
    output bit_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '{by: BY_KEEP, cf: CF_KEEP, ztest: 1'b0, inv: 1'b0};
        unique case (bit_op_e'(op))
            OP_SET:  ctrl.by = BY_SET;
            OP_CLR:  ctrl.by = BY_CLR;
            OP_FLIP: ctrl.by = BY_FLIP;
            OP_TST:  ctrl.ztest = 1'b1;
            OP_LD:   ctrl.cf = CF_LOAD;
            OP_ILD:  begin ctrl.cf = CF_LOAD; ctrl.inv = 1'b1; end
            OP_ST:   ctrl.by = BY_STORE;
            OP_IST:  begin ctrl.by = BY_STORE; ctrl.inv = 1'b1; end
            OP_AND:  ctrl.cf = CF_AND;
            OP_IAND: begin ctrl.cf = CF_AND; ctrl.inv = 1'b1; end
            OP_OR:   ctrl.cf = CF_OR;
            OP_IOR:  begin ctrl.cf = CF_OR; ctrl.inv = 1'b1; end
            OP_XOR:  ctrl.cf = CF_XOR;
            OP_IXOR: begin ctrl.cf = CF_XOR; ctrl.inv = 1'b1; end
            default: ctrl = '{by: BY_KEEP, cf: CF_KEEP, ztest: 1'b0, inv: 1'b0};
        endcase
    end
endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W   = 8,
    parameter int IDX_IN_W = 4
) (
    input  logic [IDX_IN_W-1:0] idx,
    output logic [DATA_W-1:0]   mask
);
    localparam int SEL_W = $clog2(DATA_W);
    localparam logic [IDX_IN_W-1:0] LOW_MASK = IDX_IN_W'((1 << SEL_W) - 1);

    logic [IDX_IN_W-1:0] idx_low;
    assign idx_low = idx & LOW_MASK;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign mask[i] = (idx_low == IDX_IN_W'(i));
    end

    // R1: exactly one position is selected for any index
    always_comb begin
        a_mask_onehot_r1: assert ($countones(mask) == 1 || $isunknown(idx));
    end
endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bit_ctrl_t          ctrl,
    input  logic [DATA_W-1:0]  data,
    input  logic [DATA_W-1:0]  mask,
    input  logic               c_in,
    input  logic               z_in,
    output logic [DATA_W-1:0]  data_res,
    output logic               wb,
    output logic               c_res,
    output logic               z_res
);
    logic sel_bit;
    logic opnd;
    logic c_src;

    assign sel_bit = |(data & mask);
    assign opnd    = sel_bit ^ ctrl.inv;
    assign c_src   = c_in ^ ctrl.inv;

    always_comb begin
        unique case (ctrl.by)
            BY_SET:   data_res = data | mask;
            BY_CLR:   data_res = data & ~mask;
            BY_FLIP:  data_res = data ^ mask;
            BY_STORE: data_res = (data & ~mask) | (c_src ? mask : '0);
            default:  data_res = data;
        endcase
        wb = (ctrl.by != BY_KEEP);
    end

    always_comb begin
        unique case (ctrl.cf)
            CF_LOAD: c_res = opnd;
            CF_AND:  c_res = opnd & c_in;
            CF_OR:   c_res = opnd | c_in;
            CF_XOR:  c_res = opnd ^ c_in;
            default: c_res = c_in;
        endcase
        z_res = ctrl.ztest ? ~sel_bit : z_in;
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDX_IN_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          op_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [IDX_IN_W-1:0] idx_in,
    input  logic                c_in,
    input  logic                z_in,
    output logic                out_valid,
    output logic                wb_en,
    output logic [DATA_W-1:0]   data_out,
    output logic                c_out,
    output logic                z_out
);
    typedef struct packed {
        logic              vld;
        logic              wb;
        logic [DATA_W-1:0] data;
        logic              c;
        logic              z;
    } res_t;

    bit_ctrl_t         ctrl;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] data_res;
    logic              wb_res, c_res, z_res;
    res_t              res_d, res_q;

    bitop_decode u_dec (.op(op_in), .ctrl(ctrl));

    bitop_mask #(.DATA_W(DATA_W), .IDX_IN_W(IDX_IN_W)) u_mask (
        .idx(idx_in), .mask(mask)
    );

    bitop_datapath #(.DATA_W(DATA_W)) u_dp (
        .ctrl(ctrl), .data(data_in), .mask(mask), .c_in(c_in), .z_in(z_in),
        .data_res(data_res), .wb(wb_res), .c_res(c_res), .z_res(z_res)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        res_d.wb  = 1'b0;
        if (in_valid) begin
            res_d.wb   = wb_res;
            res_d.data = data_res;
            res_d.c    = c_res;
            res_d.z    = z_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign wb_en     = res_q.wb;
    assign data_out  = res_q.data;
    assign c_out     = res_q.c;
    assign z_out     = res_q.z;

    p_wb_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid);

    p_single_bit_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(data_out ^ $past(data_in)) <= 1);

    p_z_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_in) != OP_TST) |-> z_out == $past(z_in));

    p_c_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_in) <= 4'd3 || $past(op_in) == 4'd6 || $past(op_in) == 4'd7))
        |-> c_out == $past(c_in));

    p_nop_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_in) >= 4'd14) |-> (!wb_en && data_out == $past(data_in)));
endmodule

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    // {op, data, idx, c, z, exp_data, exp_wb, exp_c, exp_z}
    localparam logic [28:0] VEC [NV] = '{
        {4'd0,  8'hA5, 4'd1,  1'b0, 1'b0, 8'hA7, 1'b1, 1'b0, 1'b0}, // R2 set
        {4'd1,  8'hA5, 4'd13, 1'b1, 1'b1, 8'h85, 1'b1, 1'b1, 1'b1}, // R1 R2 clear, idx 13->5
        {4'd2,  8'hA5, 4'd7,  1'b0, 1'b1, 8'h25, 1'b1, 1'b0, 1'b1}, // R2 flip
        {4'd3,  8'hA5, 4'd1,  1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1}, // R3 test zero bit
        {4'd3,  8'hA5, 4'd2,  1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0}, // R3 test one bit
        {4'd4,  8'hA5, 4'd0,  1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b1}, // R4 load
        {4'd5,  8'hA5, 4'd0,  1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0}, // R4 inverted load
        {4'd6,  8'hA5, 4'd1,  1'b1, 1'b0, 8'hA7, 1'b1, 1'b1, 1'b0}, // R5 store 1
        {4'd6,  8'hA5, 4'd2,  1'b0, 1'b1, 8'hA1, 1'b1, 1'b0, 1'b1}, // R5 store 0
        {4'd7,  8'hA5, 4'd0,  1'b1, 1'b0, 8'hA4, 1'b1, 1'b1, 1'b0}, // R5 inverted store
        {4'd8,  8'hA5, 4'd7,  1'b1, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b1}, // R6 and
        {4'd9,  8'hA5, 4'd7,  1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0}, // R6 inverted and
        {4'd10, 8'hA5, 4'd6,  1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b1}, // R6 or
        {4'd11, 8'hA5, 4'd6,  1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0}, // R6 inverted or
        {4'd12, 8'hA5, 4'd5,  1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b1}, // R6 xor
        {4'd13, 8'hA5, 4'd3,  1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0}, // R6 inverted xor
        {4'd15, 8'h3C, 4'd2,  1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1}  // R8 no-op
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_in = '0;
    logic [7:0] data_in = '0;
    logic [3:0] idx_in = '0;
    logic       c_in = 1'b0, z_in = 1'b0;
    logic       out_valid, wb_en, c_out, z_out;
    logic [7:0] data_out;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
        .data_in(data_in), .idx_in(idx_in), .c_in(c_in), .z_in(z_in),
        .out_valid(out_valid), .wb_en(wb_en), .data_out(data_out),
        .c_out(c_out), .z_out(z_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] d, input logic [3:0] ix,
                         input logic c, input logic z);
        @(negedge clk);
        in_valid = 1'b1; op_in = op; data_in = d; idx_in = ix; c_in = c; z_in = z;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {27'd0, out_valid, wb_en, data_out != 0, c_out, z_out}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28:25], VEC[i][24:17], VEC[i][16:13], VEC[i][12], VEC[i][11]);
            check($sformatf("R9 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
            check($sformatf("R1-R8 vec%0d data", i), {24'd0, data_out}, {24'd0, VEC[i][10:3]});
            check($sformatf("R2 R5 vec%0d wb", i), {31'd0, wb_en}, {31'd0, VEC[i][2]});
            check($sformatf("R6 R7 vec%0d c", i), {31'd0, c_out}, {31'd0, VEC[i][1]});
            check($sformatf("R3 R7 vec%0d z", i), {31'd0, z_out}, {31'd0, VEC[i][0]});
        end

        // R9: idle cycle after a write op gives no valid and no write-back
        drive(4'd0, 8'h00, 4'd4, 1'b0, 1'b0);
        check("R9 wb after set", {31'd0, wb_en}, 32'd1);
        @(negedge clk);
        check("R9 idle valid", {31'd0, out_valid}, 32'd0);
        check("R9 idle wb", {31'd0, wb_en}, 32'd0);

        // R1: index 15 aliases to bit 7
        drive(4'd0, 8'h00, 4'd15, 1'b0, 1'b0);
        check("R1 idx 15", {24'd0, data_out}, 32'h80);

        // R8: code 14 also passes everything through
        drive(4'd14, 8'h5A, 4'd1, 1'b0, 1'b1);
        check("R8 code14 data", {24'd0, data_out}, 32'h5A);
        check("R8 code14 flags", {30'd0, wb_en, c_out, z_out}, 32'b001);

        // R5: inverted store of C=0 sets a clear bit
        drive(4'd7, 8'h00, 4'd3, 1'b0, 1'b0);
        check("R5 ist c0", {24'd0, data_out}, 32'h08);

        // R10: reset clears outputs again
        drive(4'd0, 8'hFF, 4'd0, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reassert", {24'd0, data_out} | {29'd0, c_out, z_out, out_valid}, 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule